// File: doc/BRIEF.md
# Add-Subtract Unit with NZCV Flags

This block is the integer add and subtract stage of a processor datapath. It has five operations: plain add, add with carry-in from the C flag, plain subtract, subtract with borrow taken from the C flag, and negate, which is zero minus the first operand. The 32-bit result is combinational. Four flag bits (negative, zero, carry, overflow) are held in registers and load on the clock edge. Carry-in is the C flag for the chained operations, so a run of operations on successive words gives a sum or difference of any width.

The second operand is either a register value or a zero-extended immediate. Each immediate carries a range class, and the unit raises an illegal flag when the value does not fit its class. While the illegal flag is high the flags do not change. Instruction decode, the register file and write-back are outside this block.

Top module: `addsub_flags_unit`

## Requirements
- R1: Add (op code 0) outputs a+b modulo 2^32, where b is `opb_i` when `use_imm_i`=0 and the zero-extended `imm_i` otherwise. Add-with-carry (op code 1) outputs a+b+C.
- R2: Subtract (op code 2) outputs a-b. Subtract-with-carry (op code 3) outputs a-b-1 when C=0 and a-b when C=1, so C=1 means no borrow.
- R3: Negate (op code 4) outputs 0-a. It loads C=1 only when a is zero, and V=1 only when a is 0x80000000.
- R4: When the flags load, N is result bit 31 and Z is 1 when the result is all zeros. For an add, C is the unsigned carry out. For a subtract, C is 1 when no borrow occurs. V is 1 when the signed result does not fit in 32 bits.
- R5: Op codes 1, 3 and 4 always load the flags. Op codes 0 and 2 load them only when `set_flags_i`=1. In all other cycles the flags hold their value.
- R6: With `use_imm_i`=1, form 1 accepts 0..7 and form 2 accepts 0..255. Any value above that range is illegal.
- R7: With `use_imm_i`=1, form 3 (stack adjust) accepts only multiples of 4 in 0..508. Form 4 (address forming) accepts only multiples of 4 in 0..1020, and only with op code 0.
- R8: Form 0, form codes 5..7, an immediate used with op codes 1, 3 or 4, and op codes 5..7 are all illegal. When `use_imm_i`=0, the form code is ignored.
- R9: While `illegal_o` is 1, the flags do not change on the next edge.
- R10: Reset (`rst_n`=0) clears all four flags.
- R11: A flag-setting add on the low words followed by add-with-carry on each higher word gives the exact wide sum. Subtract followed by subtract-with-carry gives the exact wide difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the flag registers |
| op_i | input | 3 | Operation: 0 add, 1 add-carry, 2 sub, 3 sub-carry, 4 negate |
| set_flags_i | input | 1 | Flag load request for op codes 0 and 2 |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second register operand |
| use_imm_i | input | 1 | Use the immediate in place of `opb_i` |
| imm_i | input | 11 | Unsigned immediate |
| imm_form_i | input | 3 | Immediate range class, 1..4 |
| result_o | output | 32 | Combinational result |
| illegal_o | output | 1 | Operand combination not allowed |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry / no-borrow flag |
| flag_v_o | output | 1 | Signed overflow flag |

## Verification
The hardest cases to reach are the carry-dependent ones. The outcome of add-with-carry or subtract-with-carry depends on a C flag that an earlier, separate operation left behind. The same dependence makes it hard to show that an illegal operation leaves flags alone. The stimulus first runs edge-value operands through every op code, with the flag-load request both on and off, so each operation sees both values of C. It then sweeps every immediate from 0 to 1100 under every form with the flag-load request set, while the bench model tracks flags across cycles. Finally it runs random 64-bit addition chains and 96-bit subtraction chains and compares them with wide arithmetic.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_NEG = 3'd4
  } as_op_e;

  typedef enum logic [2:0] {
    IMM_NONE  = 3'd0,
    IMM_SHORT = 3'd1,
    IMM_LONG  = 3'd2,
    IMM_STACK = 3'd3,
    IMM_ADDR  = 3'd4
  } imm_form_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic logic op_forces_flags(input logic [2:0] op);
    return (op == OP_ADC) || (op == OP_SBC) || (op == OP_NEG);
  endfunction

  function automatic logic op_takes_imm(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/addsub_imm_check.sv
module addsub_imm_check
  import addsub_pkg::*;
#(
  parameter int IMM_W      = 11,
  parameter int SHORT_MAX  = 7,
  parameter int LONG_MAX   = 255,
  parameter int STACK_MAX  = 508,
  parameter int ADDR_MAX   = 1020,
  parameter int ALIGN_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [2:0]       form_i,
  output logic             imm_bad_o
);
  localparam int GUARD_W = IMM_W + 1;
  localparam logic [GUARD_W-1:0] SHORT_LIM = GUARD_W'(SHORT_MAX);
  localparam logic [GUARD_W-1:0] LONG_LIM  = GUARD_W'(LONG_MAX);
  localparam logic [GUARD_W-1:0] STACK_LIM = GUARD_W'(STACK_MAX);
  localparam logic [GUARD_W-1:0] ADDR_LIM  = GUARD_W'(ADDR_MAX);

  logic [GUARD_W-1:0] imm_ext;
  logic               aligned;
  logic               fits;

  assign imm_ext = {1'b0, imm_i};

  generate
    if (ALIGN_LOG2 > 0) begin : g_align
      assign aligned = (imm_i[ALIGN_LOG2-1:0] == '0);
    end else begin : g_noalign
      assign aligned = 1'b1;
    end
  endgenerate

  always_comb begin
    case (form_i)
      IMM_SHORT: fits = op_takes_imm(op_i) && (imm_ext <= SHORT_LIM);
      IMM_LONG:  fits = op_takes_imm(op_i) && (imm_ext <= LONG_LIM);
      IMM_STACK: fits = op_takes_imm(op_i) && aligned && (imm_ext <= STACK_LIM);
      IMM_ADDR:  fits = (op_i == OP_ADD) && aligned && (imm_ext <= ADDR_LIM);
      default:   fits = 1'b0;
    endcase
  end

  assign imm_bad_o = use_imm_i && !fits;

  p_short_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm_i && form_i == IMM_SHORT && !imm_bad_o) |-> (imm_i <= IMM_W'(SHORT_MAX)));
  p_stack_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm_i && form_i == IMM_STACK && !imm_bad_o) |-> (imm_i[1:0] == 2'b00));
  p_imm_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm_i && !imm_bad_o) |-> (op_i == OP_ADD || op_i == OP_SUB));

endmodule

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_flag_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  function automatic logic [W:0] add_wide(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic sign_ovf(input logic [W-1:0] x,
                                    input logic [W-1:0] y,
                                    input logic [W-1:0] s);
    return (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
  endfunction

  logic [W-1:0] x_in, y_in;
  logic         cin;
  logic [W:0]   wide;

  always_comb begin
    x_in = a_i;
    y_in = b_i;
    cin  = 1'b0;
    case (op_i)
      OP_ADC: cin = c_flag_i;
      OP_SUB: begin y_in = ~b_i; cin = 1'b1;     end
      OP_SBC: begin y_in = ~b_i; cin = c_flag_i; end
      OP_NEG: begin x_in = '0; y_in = ~a_i; cin = 1'b1; end
      default: ;
    endcase
  end

  assign wide   = add_wide(x_in, y_in, cin);
  assign sum_o  = wide[MSB:0];
  assign cout_o = wide[W];
  assign ovf_o  = sign_ovf(x_in, y_in, sum_o);

  p_neg_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NEG) |-> (cout_o == (a_i == '0)));
  p_neg_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NEG) |-> (ovf_o == (a_i == {1'b1, {MSB{1'b0}}})));
  p_sub_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SUB) |-> (cout_o == (a_i >= b_i)));

endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_i,
  input  logic [W-1:0] sum_i,
  input  logic         cout_i,
  input  logic         ovf_i,
  output nzcv_t        flags_o
);
  nzcv_t nxt;

  always_comb begin
    nxt.n = sum_i[W-1];
    nxt.z = (sum_i == '0);
    nxt.c = cout_i;
    nxt.v = ovf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_o <= '0;
    else if (upd_i) flags_o <= nxt;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(flags_o));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> (flags_o.n == $past(sum_i[W-1]) && flags_o.c == $past(cout_i)));

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import addsub_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic             set_flags_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [2:0]       imm_form_i,
  output logic [W-1:0]     result_o,
  output logic             illegal_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_c_o,
  output logic             flag_v_o
);
  nzcv_t        flags;
  logic [W-1:0] b_eff;
  logic         imm_bad;
  logic         cout, ovf;
  logic         want_flags;
  logic         flag_upd;

  assign b_eff = use_imm_i ? {{(W-IMM_W){1'b0}}, imm_i} : opb_i;

  addsub_imm_check #(.IMM_W(IMM_W)) u_imm (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .use_imm_i(use_imm_i),
    .imm_i(imm_i), .form_i(imm_form_i), .imm_bad_o(imm_bad)
  );

  addsub_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(opa_i), .b_i(b_eff),
    .c_flag_i(flags.c), .sum_o(result_o), .cout_o(cout), .ovf_o(ovf)
  );

  assign illegal_o  = imm_bad || !op_known(op_i);
  assign want_flags = op_forces_flags(op_i) || (set_flags_i && op_takes_imm(op_i));
  assign flag_upd   = want_flags && !illegal_o;

  addsub_flag_reg #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd_i(flag_upd), .sum_i(result_o),
    .cout_i(cout), .ovf_i(ovf), .flags_o(flags)
  );

  assign flag_n_o = flags.n;
  assign flag_z_o = flags.z;
  assign flag_c_o = flags.c;
  assign flag_v_o = flags.v;

  p_illegal_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> $stable(flags));
  p_forced_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NEG && !illegal_o) |=> (flags.z == ($past(opa_i) == '0)));

endmodule

// File: tb/tb_addsub_flags_unit.sv
module tb_addsub_flags_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        sf = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        ui = 1'b0;
  logic [10:0] imm = '0;
  logic [2:0]  form = 3'd0;
  logic [31:0] res;
  logic        ill, fn, fz, fc, fv;

  int errors = 0;
  int checks = 0;
  logic [3:0] mflags = 4'b0000; // model n,z,c,v

  always #2.5 clk = ~clk;

  addsub_flags_unit dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .set_flags_i(sf), .opa_i(a), .opb_i(b),
    .use_imm_i(ui), .imm_i(imm), .imm_form_i(form), .result_o(res), .illegal_o(ill),
    .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc), .flag_v_o(fv)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_illegal(input logic [2:0] o, input logic u,
                                       input logic [10:0] i, input logic [2:0] f);
    logic plain;
    plain = (o == 3'd0) || (o == 3'd2);
    if (o > 3'd4) return 1'b1;
    if (!u) return 1'b0;
    case (f)
      3'd1: return !(plain && i <= 7);
      3'd2: return !(plain && i <= 255);
      3'd3: return !(plain && i <= 508 && (i % 4) == 0);
      3'd4: return !(o == 3'd0 && i <= 1020 && (i % 4) == 0);
      default: return 1'b1;
    endcase
  endfunction

  // Applies one operation at a falling edge; checks result now and flags after the next rising edge.
  task automatic apply(input logic [2:0] o, input logic s, input logic [31:0] x,
                       input logic [31:0] y, input logic u, input logic [10:0] i,
                       input logic [2:0] f, output logic [31:0] got);
    logic [31:0] bb, er;
    logic        ec, ev, eill, upd, cin;
    longint      sd;
    logic [32:0] w;
    op = o; sf = s; a = x; b = y; ui = u; imm = i; form = f;
    bb = u ? {21'b0, i} : y;
    cin = mflags[1];
    er = '0; ec = 1'b0; ev = 1'b0;
    case (o)
      3'd0, 3'd1: begin // R1
        w  = {1'b0, x} + {1'b0, bb} + ((o == 3'd1 && cin) ? 33'd1 : 33'd0);
        er = w[31:0]; ec = w[32];
        sd = longint'($signed(x)) + longint'($signed(bb)) + ((o == 3'd1 && cin) ? 1 : 0);
        ev = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
      end
      3'd2, 3'd3: begin // R2
        longint unsigned bor;
        bor = (o == 3'd3 && !cin) ? 1 : 0;
        er = x - bb - 32'(bor);
        ec = (longint'({32'b0, x}) >= longint'({32'b0, bb}) + longint'(bor));
        sd = longint'($signed(x)) - longint'($signed(bb)) - longint'(bor);
        ev = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
      end
      3'd4: begin // R3
        er = -x; ec = (x == 0); ev = (x == 32'h8000_0000);
      end
      default: ;
    endcase
    eill = exp_illegal(o, u, i, f);
    upd  = !eill && ((o == 3'd1) || (o == 3'd3) || (o == 3'd4) || (s && (o == 3'd0 || o == 3'd2)));
    #1;
    got = res;
    chk(ill == eill, "R6/R7/R8 illegal", {63'b0, ill}, {63'b0, eill});
    if (!eill) chk(res == er, "R1/R2/R3 result", {32'b0, res}, {32'b0, er});
    if (upd) mflags = {er[31], er == 0, ec, ev};
    @(negedge clk);
    chk({fn, fz, fc, fv} == mflags,
        eill ? "R9 flags kept on illegal" : (upd ? "R4 flags loaded" : "R5 flags held"),
        {60'b0, fn, fz, fc, fv}, {60'b0, mflags});
  endtask

  logic [31:0] edges [8] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000,
                             32'hffff_ffff, 32'h1234_5678, 32'h8000_0001, 32'hfffe_0002};

  initial begin : wd
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] r0, r1, r2;
    repeat (3) @(negedge clk);
    chk({fn, fz, fc, fv} == 4'b0, "R10 reset clears flags", {60'b0, fn, fz, fc, fv}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // edge-value operand sweep across every op and flag-load request
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 2; s++)
        for (int x = 0; x < 8; x++)
          for (int y = 0; y < 8; y++)
            apply(3'(o), s[0], edges[x], edges[y], 1'b0, 11'd0, 3'(y), r0);

    // immediate sweep for every form, with the flag-load request set (R6 R7 R8 R9)
    for (int f = 0; f < 8; f++)
      for (int i = 0; i <= 1100; i++) begin
        apply(3'd0, 1'b1, 32'hffff_fff8 + 32'(i % 16), 32'h0, 1'b1, 11'(i), 3'(f), r0);
        apply(3'd2, 1'b1, 32'(i % 9), 32'h0, 1'b1, 11'(i), 3'(f), r0);
      end
    for (int o = 1; o < 5; o += 2)
      apply(3'(o), 1'b1, 32'h5, 32'h3, 1'b1, 11'd4, 3'd1, r0); // R8 immediate with a carry op
    apply(3'd4, 1'b0, 32'h5, 32'h3, 1'b1, 11'd4, 3'd2, r0);

    // multiword chains (R11)
    for (int k = 0; k < 200; k++) begin
      logic [63:0] p, q, s64;
      logic [95:0] u, v, d96;
      p = {$urandom(), $urandom()}; q = {$urandom(), $urandom()};
      if (k % 5 == 0) q = ~p;
      s64 = p + q;
      apply(3'd0, 1'b1, p[31:0], q[31:0], 1'b0, 11'd0, 3'd0, r0);
      apply(3'd1, 1'b0, p[63:32], q[63:32], 1'b0, 11'd0, 3'd0, r1);
      chk({r1, r0} == s64, "R11 64-bit sum", {r1, r0}, s64);
      u = {$urandom(), $urandom(), $urandom()}; v = {$urandom(), $urandom(), $urandom()};
      if (k % 7 == 0) v = u;
      if (k % 7 == 1) v = u + 96'd1;
      d96 = u - v;
      apply(3'd2, 1'b1, u[31:0], v[31:0], 1'b0, 11'd0, 3'd0, r0);
      apply(3'd3, 1'b0, u[63:32], v[63:32], 1'b0, 11'd0, 3'd0, r1);
      apply(3'd3, 1'b0, u[95:64], v[95:64], 1'b0, 11'd0, 3'd0, r2);
      chk({r2, r1, r0} == d96, "R11 96-bit difference", {r1, r0}, d96[63:0]);
      chk(fc == (u >= v), "R11 final no-borrow", {63'b0, fc}, {63'b0, (u >= v)});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule